// File: doc/BRIEF.md
# GPIO Port Drive-Mode Controller

This block controls one general-purpose I/O port of eight pins. Software selects one of four pin drive behaviours for each pin and sets a per-pin output level. Every pin takes a two-bit drive mode. The low bit of that mode sits in one mode register and the high bit sits in a second mode register, both at the pin's own bit position. The block turns the mode and the output level into four pad control lines per pin: output enable, driven value, pull-up enable and digital input-buffer enable.

The pin levels coming back from the pads pass through a synchronizer. A read of the data address returns those synchronized levels. Any pin in the analog high-impedance mode has its digital input switched off, so it reads as zero and never raises a change interrupt. Every other pin latches a sticky flag when its synchronized level changes. Software clears a flag by writing one to that bit at the status address. A single interrupt line is high while any flag is set.

The register interface is one byte wide with a two-bit address. It has a single-cycle write strobe and a combinational read path. Address 0 is data, 1 is mode-low, 2 is mode-high and 3 is interrupt status.

Top module: `gpio_drive_port`

## Requirements
- R1: After reset the mode-high register (address 2) reads 0xFF, the mode-low register (address 1) reads 0x00 and the data register holds 0x00. Every pin therefore starts in mode 10: all pad enables are low and a read of address 0 returns 0x00 whatever the pins carry.
- R2: The mode of pin n is {bit n of address 2, bit n of address 1}. A write takes effect on the pad outputs from the clock edge that samples the strobe.
- R3: In mode 00 (pull-up), data 1 gives pull-up on and output enable off, while data 0 gives output enable on with driven value 0 and pull-up off. Input enable is on.
- R4: In mode 01 (strong), output enable is on and the driven value equals the data bit. Pull-up is off and input enable is on.
- R5: In mode 10 (analog high-impedance), output enable, driven value, pull-up and input enable are all off.
- R6: In mode 11 (open-drain low), data 0 gives output enable on with driven value 0, and data 1 releases the pin with output enable off. Pull-up is off and input enable is on, so a released pin works as an input.
- R7: A read of address 0 returns the pin inputs after two clock edges of synchronization. Bits of pins in mode 10 read as 0.
- R8: A non-analog pin's flag, read at address 3, is set one clock edge after its synchronized level changes. The interrupt output is the OR of all flags.
- R9: Writing address 3 clears each flag whose write-data bit is 1 and leaves the other flags unchanged.
- R10: A pin in mode 10 never sets its flag, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_ie | output | 8 | Per-pin digital input enable |
| port_irq | output | 1 | High while any change flag is set |

## Verification
The pad controls are combinational from the registers, so the bench samples them at the falling edge that follows the write edge. A pin change the bench drives at a falling edge shows in the address-0 read after two rising edges. The bench samples once after the first edge, expecting the old value, and again after the second, expecting the new one. The change flag follows one rising edge later, so flag reads wait three falling edges after the stimulus. All inputs move on falling edges, and the combinational read is sampled 1 ns after the address settles.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  typedef enum logic [1:0] {
    DM_PULLUP  = 2'b00,
    DM_STRONG  = 2'b01,
    DM_ANALOG  = 2'b10,
    DM_OPEN_LO = 2'b11
  } drive_mode_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
    logic ie;
  } pad_ctrl_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_DM0  = 2'd1;
  localparam logic [1:0] ADDR_DM1  = 2'd2;
  localparam logic [1:0] ADDR_IRQ  = 2'd3;

  // Map a drive mode and data bit onto pad controls
  function automatic pad_ctrl_t decode_pad(input drive_mode_e mode, input logic dat);
    pad_ctrl_t p;
    p = '0;
    unique case (mode)
      DM_PULLUP: begin
        p.oe = ~dat;
        p.pu = dat;
        p.ie = 1'b1;
      end
      DM_STRONG: begin
        p.oe  = 1'b1;
        p.out = dat;
        p.ie  = 1'b1;
      end
      DM_ANALOG: p = '0;
      DM_OPEN_LO: begin
        p.oe = ~dat;
        p.ie = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] data_q,
  output logic [NUM_PINS-1:0] dm0_q,
  output logic [NUM_PINS-1:0] dm1_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dm0_q  <= '0;
      dm1_q  <= '1;
    end else if (wr) begin
      case (addr)
        ADDR_DATA: data_q <= wdata;
        ADDR_DM0:  dm0_q  <= wdata;
        ADDR_DM1:  dm1_q  <= wdata;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] lvl,
  output logic [NUM_PINS-1:0] toggled
);

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] stage_q;
  logic [NUM_PINS-1:0]                  prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[SYNC_STAGES-1];
    end
  end

  assign lvl     = stage_q[SYNC_STAGES-1];
  assign toggled = lvl ^ prev_q;

endmodule

// File: rtl/gpio_pin_slice.sv
`timescale 1ns/1ps
module gpio_pin_slice
  import gpio_port_pkg::*;
(
  input  logic dm0,
  input  logic dm1,
  input  logic dat,
  output logic oe,
  output logic out,
  output logic pu,
  output logic ie
);

  pad_ctrl_t ctl;

  always_comb ctl = decode_pad(drive_mode_e'({dm1, dm0}), dat);

  assign oe  = ctl.oe;
  assign out = ctl.out;
  assign pu  = ctl.pu;
  assign ie  = ctl.ie;

endmodule

// File: rtl/gpio_irq_flags.sv
`timescale 1ns/1ps
module gpio_irq_flags #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_evt,
  input  logic                clr_wr,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] flags_q
);

  logic [NUM_PINS-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;

  // A new event in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_eff) | set_evt;
  end

endmodule

// File: rtl/gpio_drive_port.sv
`timescale 1ns/1ps
module gpio_drive_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic [NUM_PINS-1:0] pad_ie,
  output logic                port_irq
);

  logic [NUM_PINS-1:0] data_q, dm0_q, dm1_q;
  logic [NUM_PINS-1:0] sync_lvl, sync_toggled;
  logic [NUM_PINS-1:0] analog_mask, pullup_mask;
  logic [NUM_PINS-1:0] flag_set_evt, irq_flags;
  logic                irq_clr_wr;

  gpio_port_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .data_q(data_q), .dm0_q(dm0_q), .dm1_q(dm1_q)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .lvl(sync_lvl), .toggled(sync_toggled)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    gpio_pin_slice slice_i (
      .dm0(dm0_q[n]), .dm1(dm1_q[n]), .dat(data_q[n]),
      .oe(pad_oe[n]), .out(pad_out[n]), .pu(pad_pu[n]), .ie(pad_ie[n])
    );
  end

  // Named mode masks used for read masking and by the checker
  assign analog_mask  = dm1_q & ~dm0_q;
  assign pullup_mask  = ~dm1_q & ~dm0_q;
  assign flag_set_evt = sync_toggled & ~analog_mask;
  assign irq_clr_wr   = bus_wr && (bus_addr == ADDR_IRQ);

  gpio_irq_flags #(.NUM_PINS(NUM_PINS)) irq_i (
    .clk(clk), .rst_n(rst_n), .set_evt(flag_set_evt),
    .clr_wr(irq_clr_wr), .clr_mask(bus_wdata), .flags_q(irq_flags)
  );

  assign port_irq = |irq_flags;

  always_comb begin
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = sync_lvl & ~analog_mask;
      ADDR_DM0:  bus_rdata = dm0_q;
      ADDR_DM1:  bus_rdata = dm1_q;
      default:   bus_rdata = irq_flags;
    endcase
  end

endmodule

// File: rtl/gpio_drive_port_chk.sv
`timescale 1ns/1ps
module gpio_drive_port_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] analog_mask,
  input logic [NUM_PINS-1:0] pullup_mask,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_pu,
  input logic [NUM_PINS-1:0] pad_ie,
  input logic [NUM_PINS-1:0] flag_set_evt,
  input logic [NUM_PINS-1:0] irq_flags,
  input logic                port_irq
);

  p_analog_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | pad_pu | pad_ie) & analog_mask) == '0);

  p_pullup_only_mode00_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & ~pullup_mask) == '0);

  p_high_needs_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  p_ie_tracks_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_ie == ~analog_mask);

  p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
    port_irq == (irq_flags != '0));

  p_flag_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_flags & ~$past(irq_flags) & ~$past(flag_set_evt)) == '0);

  p_no_flag_analog_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_flags & ~$past(irq_flags) & $past(analog_mask)) == '0);

endmodule

bind gpio_drive_port gpio_drive_port_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .analog_mask(analog_mask), .pullup_mask(pullup_mask),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_ie(pad_ie),
  .flag_set_evt(flag_set_evt), .irq_flags(irq_flags), .port_irq(port_irq)
);

// File: tb/gpio_drive_port_tb.sv
`timescale 1ns/1ps
module gpio_drive_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] pad_oe, pad_out, pad_pu, pad_ie;
  logic       port_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  gpio_drive_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_ie(pad_ie),
    .port_irq(port_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Expected pad controls {oe,out,pu,ie} for one pin, from the requirements
  function automatic logic [3:0] want_pad(input logic hi, input logic lo, input logic d);
    if (hi && !lo)  return 4'b0000;                 // R5 analog
    if (!hi && lo)  return {1'b1, d, 1'b0, 1'b1};   // R4 strong
    if (!hi && !lo) return {~d, 1'b0, d, 1'b1};     // R3 pull-up
    return {~d, 1'b0, 1'b0, 1'b1};                  // R6 open-drain low
  endfunction

  task automatic check_pads(input string req, input logic [7:0] m0, input logic [7:0] m1,
                            input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      check(req, {pad_oe[i], pad_out[i], pad_pu[i], pad_ie[i]}, want_pad(m1[i], m0[i], d[i]));
    end
  endtask

  task automatic t_reset();
    logic [7:0] r;
    bus_read(2'd2, r); check("R1 dm-high reset", r, 8'hFF);
    bus_read(2'd1, r); check("R1 dm-low reset", r, 8'h00);
    bus_read(2'd0, r); check("R1 data read masked", r, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pu", pad_pu, 8'h00);
    check("R1 ie", pad_ie, 8'h00);
    check("R1 irq", port_irq, 1'b0);
  endtask

  task automatic t_modes();
    logic [7:0] r;
    bus_write(2'd1, 8'hAA);
    bus_write(2'd2, 8'hCC);
    bus_read(2'd1, r); check("R2 dm-low readback", r, 8'hAA);
    bus_read(2'd2, r); check("R2 dm-high readback", r, 8'hCC);
    bus_write(2'd0, 8'hF0);
    check_pads("R2 R3 R4 R5 R6 data F0", 8'hAA, 8'hCC, 8'hF0);
    bus_write(2'd0, 8'h0F);
    check_pads("R2 R3 R4 R5 R6 data 0F", 8'hAA, 8'hCC, 8'h0F);
    bus_write(2'd0, 8'h5A);
    check_pads("R2 R3 R4 R5 R6 data 5A", 8'hAA, 8'hCC, 8'h5A);
  endtask

  task automatic t_read_sync();
    logic [7:0] r;
    @(negedge clk); pin_in = 8'h00;
    repeat (4) @(negedge clk);
    @(negedge clk); pin_in = 8'hFF;
    @(negedge clk);
    bus_read(2'd0, r); check("R7 one edge still old", r, 8'h00);
    @(negedge clk);
    bus_read(2'd0, r); check("R7 two edges masked", r, 8'hBB);
  endtask

  task automatic t_irq();
    logic [7:0] r;
    repeat (3) @(negedge clk);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, r); check("R9 cleared all", r, 8'h00);
    check("R8 irq low", port_irq, 1'b0);
    pin_in = 8'h00;
    repeat (2) @(negedge clk);
    bus_read(2'd3, r); check("R8 not yet set", r, 8'h00);
    @(negedge clk);
    bus_read(2'd3, r); check("R8 R10 flags set", r, 8'hBB);
    check("R8 irq high", port_irq, 1'b1);
    bus_write(2'd3, 8'h0F);
    bus_read(2'd3, r); check("R9 partial clear", r, 8'hB0);
    check("R8 irq still high", port_irq, 1'b1);
    bus_write(2'd3, 8'hF0);
    bus_read(2'd3, r); check("R9 rest cleared", r, 8'h00);
    check("R8 irq low again", port_irq, 1'b0);
  endtask

  task automatic t_analog_silent();
    logic [7:0] r;
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'hFF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pin_in = ~pin_in;
      repeat (3) @(negedge clk);
    end
    bus_read(2'd3, r); check("R10 no flags in analog", r, 8'h00);
    check("R10 irq low", port_irq, 1'b0);
    bus_read(2'd0, r); check("R5 R7 analog reads zero", r, 8'h00);
  endtask

  task automatic t_open_drain();
    logic [7:0] r;
    bus_write(2'd0, 8'hFF);
    bus_write(2'd1, 8'hFF);
    check("R6 released oe", pad_oe, 8'h00);
    check("R6 ie on", pad_ie, 8'hFF);
    check("R6 pu off", pad_pu, 8'h00);
    bus_write(2'd3, 8'hFF);
    pin_in = 8'h5A;
    repeat (2) @(negedge clk);
    bus_read(2'd0, r); check("R6 R7 shared input", r, 8'h5A);
    bus_write(2'd0, 8'h0F);
    check("R6 low drive oe", pad_oe, 8'hF0);
    check("R6 out zero", pad_out, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_read_sync();
    t_irq();
    t_analog_silent();
    t_open_drain();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule